// File: doc/BRIEF.md
# Two-Wire Register-File Slave with Auto-Incrementing Pointer

This block is a two-wire (I2C) slave that gives a host access to a 64-byte register space. Bytes 0 to 7 hold the timekeeping words (seconds, minutes, hours, weekday, day of month, month, year, control) and bytes 8 to 63 are general RAM. The storage itself sits outside the block and is reached through a simple port. The port carries an address that always shows the internal pointer, a one-cycle write strobe with write data, and read data that the storage returns combinationally for the shown address. The bus lines arrive as raw levels and are brought into the system clock domain by a synchronizer. The block pulls SDA low through an open-drain enable, which is high when the line must be pulled low.

A write transfer loads the pointer from the first byte after the device address. Each later byte is stored at the pointer and the pointer then advances. A read transfer streams bytes from the pointer, and the pointer advances only when the master acknowledges. The pointer survives between transfers, so a read that follows a bare START continues where the last access left off. A power-fail input aborts whatever is in progress, clears the pointer and blocks the bus until it drops.

The protocol engine has nine states. ST_IDLE waits for START. ST_ADDR shifts in the device address; a match goes to ST_ADDR_ACK and a mismatch goes back to ST_IDLE. ST_ADDR_ACK goes to ST_RDATA for a read and to ST_WADDR for a write. ST_WADDR shifts in the word address and goes to ST_WADDR_ACK. ST_WADDR_ACK and ST_WDATA_ACK both lead to ST_WDATA. ST_WDATA goes to ST_WDATA_ACK once a full byte is in. ST_RDATA shifts out a byte and goes to ST_RACK. ST_RACK goes back to ST_RDATA if the master acknowledges and to ST_IDLE if it does not. From any state, START goes to ST_ADDR, while STOP and power-fail go to ST_IDLE.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The device address is 7'b1101000, so the first byte after START is 0xD0 for a write and 0xD1 for a read. On a match, sda_drive_low is 1 throughout the ninth clock.
- R2: A device address that does not match gets no acknowledge. The slave returns to idle and ignores further bytes, with no write strobe and no SDA drive, until the next START. The pointer is left unchanged.
- R3: In a write, the low 6 bits of the first byte after the address load the pointer. Each later byte gives a one-cycle reg_we with reg_addr equal to the pointer and reg_wdata equal to the byte, and the pointer then advances. The word address and every data byte are acknowledged.
- R4: In a read, bytes are sent MSB first, starting from the pointer. The pointer advances only when the master holds SDA low in the ninth clock.
- R5: A master that does not acknowledge ends the read. The slave releases SDA and drives nothing on further clocks until the next START.
- R6: A repeated START after a word-address write turns the transfer into a read that starts at the newly loaded pointer.
- R7: A read that comes directly after START starts at the stored pointer. The pointer keeps its value across STOP and is 0 after reset.
- R8: The pointer wraps from 63 to 0, for both writes and reads.
- R9: While pwr_fail is 1, any transfer is abandoned and SDA is released within one cycle. The pointer is held at 0, and bus activity gives no acknowledge and no write.
- R10: START is SDA falling while SCL is high and STOP is SDA rising while SCL is high. STOP in the middle of a byte ends the transfer with no write. The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL level from the bus |
| sda_in | input | 1 | Raw SDA level from the bus |
| sda_drive_low | output | 1 | Open-drain enable, 1 pulls SDA low |
| pwr_fail | input | 1 | Supply out of tolerance, aborts and blocks the bus |
| reg_addr | output | 6 | Register-file address (current pointer) |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | One-cycle register-file write strobe |
| reg_rdata | input | 8 | Register-file read data for reg_addr, combinational |

## Verification
The assertions assume a master that keeps SDA steady while SCL is high, except when it signals START or STOP. They also assume that SCL and SDA stay at a level for several clock cycles, longer than the synchronizer depth. Finally, they assume a reading master ends each read with a not-acknowledge before it sends STOP, since a STOP cannot be seen while the slave is holding the line low. The bench master holds each SCL phase for eight clocks and moves SDA two clocks after a falling SCL edge. It always ends a read with a not-acknowledge and raises power-fail only while SCL is low. Pointers, burst lengths and data are drawn at random from a fixed seed, and directed cases cover wrap, a wrong address, an early STOP and power-fail.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } rfs_state_e;
endpackage

// File: rtl/rfs_line_sync.sv
module rfs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    // Idle bus is high, so reset to ones to avoid a false edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/rfs_pointer.sv
module rfs_pointer #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] ptr
);
    localparam int              DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (clr) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_val;
        end else if (inc) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !load && ptr == LAST) |=> (ptr == '0)); // R8

    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ptr == '0)); // R9
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import rfs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1101000,
    parameter int         ADDR_W      = 6,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_drive_low,
    input  logic              pwr_fail,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int              CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    rfs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    rfs_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BYTE_W-1:0] rx_q, rx_d;
    logic [BYTE_W-1:0] tx_q, tx_d;
    logic              rw_q, rw_d;
    logic              mack_q, mack_d;
    logic              ptr_clr, ptr_load, ptr_inc, we_c;
    logic [ADDR_W-1:0] ptr;

    rfs_pointer #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ptr_clr),
        .load     (ptr_load),
        .load_val (rx_q[ADDR_W-1:0]),
        .inc      (ptr_inc),
        .ptr      (ptr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rx_q    <= '0;
            tx_q    <= '1;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rx_q    <= rx_d;
            tx_q    <= tx_d;
            rw_q    <= rw_d;
            mack_q  <= mack_d;
        end
    end

    // Next state and datapath control
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        rx_d     = rx_q;
        tx_d     = tx_q;
        rw_d     = rw_q;
        mack_d   = mack_q;
        ptr_clr  = 1'b0;
        ptr_load = 1'b0;
        ptr_inc  = 1'b0;
        we_c     = 1'b0;
        if (pwr_fail) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            ptr_clr = 1'b1;
        end else if (start_det) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
        end else if (stop_det) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_ADDR, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        rx_d  = {rx_q[BYTE_W-2:0], sda_s};
                        cnt_d = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == CNT_FULL) begin
                        cnt_d = '0;
                        if (state_q == ST_ADDR) begin
                            if (rx_q[BYTE_W-1:1] == DEV_ADDR) begin
                                rw_d    = rx_q[0];
                                state_d = ST_ADDR_ACK;
                            end else begin
                                state_d = ST_IDLE;
                            end
                        end else if (state_q == ST_WADDR) begin
                            ptr_load = 1'b1;
                            state_d  = ST_WADDR_ACK;
                        end else begin
                            we_c    = 1'b1;
                            ptr_inc = 1'b1;
                            state_d = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt_d = '0;
                        if (rw_q) begin
                            tx_d    = reg_rdata;
                            state_d = ST_RDATA;
                        end else begin
                            state_d = ST_WADDR;
                        end
                    end
                end
                ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        cnt_d   = '0;
                        state_d = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        cnt_d = cnt_q + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt_q == CNT_FULL) begin
                            cnt_d   = '0;
                            state_d = ST_RACK;
                        end else begin
                            tx_d = {tx_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack_d  = ~sda_s;
                        ptr_inc = ~sda_s;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            tx_d    = reg_rdata;
                            cnt_d   = '0;
                            state_d = ST_RDATA;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_drive_low = 1'b1;
            ST_RDATA:                                sda_drive_low = ~tx_q[BYTE_W-1];
            default:                                 sda_drive_low = 1'b0;
        endcase
        reg_we    = we_c;
        reg_wdata = rx_q;
        reg_addr  = ptr;
    end

    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R3

    AST_PFAIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (!sda_drive_low && !reg_we)); // R9

    AST_DRIVE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_drive_low) && !$past(pwr_fail)) |-> !$past(scl_s)); // R10

    AST_NO_WE_WHILE_READING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RDATA || state_q == ST_RACK) |-> !reg_we); // R4
endmodule

// File: tb/sim_i2c_regfile_slave.sv
module sim_i2c_regfile_slave;
    localparam int Q     = 8;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n, scl_m, sda_m, pwr_fail;
    logic       drv, we;
    logic [5:0] raddr;
    logic [7:0] wdata, rdata;
    wire        sda_line = sda_m & ~drv;

    logic [7:0] mem [DEPTH];
    logic [7:0] exp_mem [DEPTH];
    int exp_ptr = 0;
    int we_cnt = 0;
    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    i2c_regfile_slave u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_m),
        .sda_in        (sda_line),
        .sda_drive_low (drv),
        .pwr_fail      (pwr_fail),
        .reg_addr      (raddr),
        .reg_wdata     (wdata),
        .reg_we        (we),
        .reg_rdata     (rdata)
    );

    assign rdata = mem[raddr];

    always @(posedge clk) begin
        if (we) begin
            mem[raddr] <= wdata;
            we_cnt     <= we_cnt + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            total++;
            bad++;
            $display("FAIL watchdog all-R actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int nxt(input int p);
        return (p + 1) % DEPTH;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(Q);
            scl_m = 1'b0; tick(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q / 2);
        acked = (sda_line == 1'b0);
        tick(Q / 2);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q / 2);
            b[i] = sda_line;
            tick(Q / 2);
            scl_m = 1'b0; tick(2);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        scl_m = 1'b0; tick(2);
        sda_m = 1'b1;
    endtask

    task automatic write_burst(input int start, input int n);
        bit   ack;
        int   we0;
        logic [7:0] d;
        we0 = we_cnt;
        bus_start();
        send_byte(8'hD0, ack);
        check(ack, "R1", "write address ack", ack, 1);
        send_byte(8'(start), ack);
        check(ack, "R3", "word address ack", ack, 1);
        exp_ptr = start % DEPTH;
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d, ack);
            check(ack, (exp_ptr == 0 && k > 0) ? "R8" : "R3", "data ack", ack, 1);
            exp_mem[exp_ptr] = d;
            exp_ptr = nxt(exp_ptr);
        end
        bus_stop();
        check(we_cnt - we0 == n, "R3", "write strobes", we_cnt - we0, n);
    endtask

    task automatic read_burst(input bit set_ptr, input int start, input int n);
        bit   ack;
        logic [7:0] b;
        string tg;
        bus_start();
        if (set_ptr) begin
            send_byte(8'hD0, ack);
            check(ack, "R1", "write address ack", ack, 1);
            send_byte(8'(start), ack);
            check(ack, "R6", "word address ack", ack, 1);
            exp_ptr = start % DEPTH;
            bus_start();
        end
        send_byte(8'hD1, ack);
        check(ack, "R1", "read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            if (k == 0) tg = set_ptr ? "R6" : "R7";
            else if (exp_ptr == 0) tg = "R8";
            else tg = "R4";
            check(b == exp_mem[exp_ptr], tg, "read data", b, exp_mem[exp_ptr]);
            if (k < n - 1) exp_ptr = nxt(exp_ptr);
        end
        bus_stop();
    endtask

    initial begin
        bit   ack;
        int   err, we0;
        logic [6:0] wrong;
        logic [7:0] b;

        void'($urandom(32'h5A17));
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]     = 8'($urandom);
            exp_mem[i] = mem[i];
        end
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; pwr_fail = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // Reset state
        check(drv == 1'b0, "R10", "reset sda drive", drv, 0);
        check(we == 1'b0, "R3", "reset write strobe", we, 0);
        check(raddr == 6'd0, "R7", "reset pointer", raddr, 0);

        // Current-pointer read after reset starts at 0
        read_burst(1'b0, 0, 2);

        // Random mix
        for (int it = 0; it < 10; it++) begin
            write_burst($urandom_range(0, 63), $urandom_range(1, 6));
            read_burst(1'b1, $urandom_range(0, 63), $urandom_range(1, 5));
            read_burst(1'b0, 0, $urandom_range(1, 3));
        end

        // Wrap 63 -> 0 on write and read
        write_burst(62, 4);
        read_burst(1'b1, 63, 3);

        // Non-matching address: no ack, nothing written, pointer kept
        do wrong = 7'($urandom); while (wrong == 7'b1101000);
        we0 = we_cnt;
        bus_start();
        send_byte({wrong, 1'($urandom)}, ack);
        check(!ack, "R2", "foreign address ack", ack, 0);
        send_byte(8'h00, ack);
        check(!ack, "R2", "byte after foreign address ack", ack, 0);
        send_byte(8'h5C, ack);
        check(!ack, "R2", "second byte after foreign address", ack, 0);
        bus_stop();
        check(we_cnt == we0, "R2", "writes after foreign address", we_cnt - we0, 0);
        read_burst(1'b0, 0, 1);

        // Master NACK: release, no pointer advance
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'd20, ack);
        bus_start();
        send_byte(8'hD1, ack);
        recv_byte(1'b0, b);
        exp_ptr = 20;
        check(b == exp_mem[20], "R6", "nack read data", b, exp_mem[20]);
        err = 0;
        for (int j = 0; j < 9; j++) begin
            tick(Q);
            scl_m = 1'b1; tick(Q / 2);
            if (sda_line !== 1'b1) err++;
            tick(Q / 2);
            scl_m = 1'b0; tick(2);
        end
        check(err == 0, "R5", "drive after nack", err, 0);
        bus_stop();
        read_burst(1'b0, 0, 1);

        // Power-fail in the middle of a data byte
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'd5, ack);
        send_bits(8'h3C, 4);
        pwr_fail = 1'b1;
        tick(2);
        check(drv == 1'b0, "R9", "drive during power fail", drv, 0);
        we0 = we_cnt;
        bus_start();
        send_byte(8'hD0, ack);
        check(!ack, "R9", "address ack under power fail", ack, 0);
        send_byte(8'd9, ack);
        send_byte(8'hA5, ack);
        check(!ack, "R9", "data ack under power fail", ack, 0);
        bus_stop();
        check(we_cnt == we0, "R9", "writes under power fail", we_cnt - we0, 0);
        check(raddr == 6'd0, "R9", "pointer under power fail", raddr, 0);
        pwr_fail = 1'b0;
        tick(4);
        exp_ptr = 0;
        read_burst(1'b0, 0, 2);

        // STOP in the middle of a data byte
        we0 = we_cnt;
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'd33, ack);
        exp_ptr = 33;
        send_bits(8'hF0, 3);
        bus_stop();
        check(we_cnt == we0, "R10", "write after early stop", we_cnt - we0, 0);
        check(drv == 1'b0, "R10", "drive after stop", drv, 0);
        read_burst(1'b0, 0, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule